// File: doc/BRIEF.md
# Gated 13-Bit Counter/Timer

This block holds a set of counter/timer channels (two by default). Each channel has a 13-bit count made of a 5-bit low field and an 8-bit high field. The count advances on one of three sources: every system clock, a one-cycle prescaler tick from outside the block, or a falling edge on the channel's count pin. Every channel has its own run bit and its own gate input. When gating is on, the channel counts only while its gate pin is high, so a high pulse can be measured by clearing the count, enabling gating and reading the count afterwards.

Software reaches each channel through a plain register port. It has a single-cycle write strobe and a combinational read path. No data streams through the block, so the port has no valid/ready handshake and every write is accepted in the cycle it is strobed. A channel whose count wraps from all ones to zero raises a sticky overflow flag. The flag drives the channel's interrupt request line.

Top module: `gated_timer13`

## Requirements
- R1: When ctrl bit 2 (pin source) is 1, each high-to-low transition on the channel's `cnt_pin` adds exactly one to the count. The increment lands on the third rising clock edge after the pin changes (two synchronizer flops plus one count register). A pin held low adds nothing further.
- R2: When ctrl bit 2 is 0, ctrl bit 3 picks the internal source. With bit 3 at 1 the count advances on every clock. With bit 3 at 0 it advances only on cycles where `presc_tick` is 1.
- R3: Counting is enabled when ctrl bit 0 (run) is 1 and either ctrl bit 1 (gate enable) is 0 or the synchronized `gate_pin` of that channel is 1. The gate pin passes through two flops. In every other combination the count holds.
- R4: Writing the ctrl register, including setting run, leaves the count unchanged.
- R5: The register at sel 0 holds the low 5 count bits in bits 4:0. The register at sel 1 holds the upper 8 bits. The low field carries into the high register when it passes 31. Bits 7:5 at sel 0 read back as written and never change by counting.
- R6: When the 13-bit count steps from 0x1FFF to 0, ctrl bit 4 (overflow flag) is set and `ovf_irq` for that channel goes high.
- R7: The flag stays set until a ctrl write with bit 4 at 0, or a one-cycle pulse on `ovf_ack`. A ctrl write takes precedence over an acknowledge. A wrap in the same cycle as either kind of clear leaves the flag set.
- R8: A write to sel 0 or sel 1 of a channel suppresses that channel's increment in the same cycle. The written value is loaded unchanged, and the other count register keeps its value.
- R9: After reset, all count registers, control bits and flags read 0, and `ovf_irq` is 0.
- R10: Register address = {channel, sel}, with sel 0 low, 1 high, 2 ctrl, and 3 reading 0. Channels count, gate and flag independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W (3) | Register address {channel, sel}, used for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| presc_tick | input | 1 | Prescaled clock enable pulse, shared by all channels |
| cnt_pin | input | NCH (2) | External count pins, asynchronous |
| gate_pin | input | NCH (2) | External active-high gate pins, asynchronous |
| ovf_ack | input | NCH (2) | Overflow acknowledge pulses |
| ovf_irq | output | NCH (2) | Overflow interrupt requests (sticky flags) |

## Verification
The hardest case to reach is the wrap landing on the same clock edge as a flag clear. From the ports, this needs the run period timed so that the final increment and the ctrl write fall on one edge. The bench loads the count with 0x1FFE, starts the clock source and issues the stopping ctrl write exactly two edges later, which produces that collision. A second case is the write-versus-increment race. Here the bench writes the low and high registers back to back while the channel is running, and checks the value that results from the known mix of written and counted edges.

// File: rtl/timer13_pkg.sv
package timer13_pkg;
  localparam int LOW_BITS  = 5;
  localparam int HIGH_BITS = 8;
  localparam int CNT_BITS  = LOW_BITS + HIGH_BITS;
  localparam int DATA_W    = 8;

  // control register bit positions
  localparam int B_RUN  = 0;
  localparam int B_GATE = 1;
  localparam int B_PIN  = 2;
  localparam int B_SYS  = 3;
  localparam int B_OVF  = 4;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic sys_sel;
    logic pin_sel;
    logic gate_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign level = sh[STAGES-1];
  assign fall  = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/timer13_channel.sv
module timer13_channel
  import timer13_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_low,
  input  logic                wr_high,
  input  logic                wr_ctrl,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                presc_tick,
  input  logic                cnt_pin,
  input  logic                gate_pin,
  input  logic                ovf_ack,
  output logic [DATA_W-1:0]   low_q,
  output logic [HIGH_BITS-1:0] high_q,
  output logic [DATA_W-1:0]   ctrl_rd,
  output logic [CNT_BITS-1:0] cnt_q,
  output logic                ovf_q
);
  ctrl_t ctrl_q;
  logic  gate_lvl, pin_fall, unused_pin_lvl, unused_gate_fall;
  logic  tick, enable, step, wrap;
  logic [CNT_BITS-1:0] cnt_nxt;

  pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_pin),
    .level(unused_pin_lvl), .fall(pin_fall)
  );
  pin_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .din(gate_pin),
    .level(gate_lvl), .fall(unused_gate_fall)
  );

  assign cnt_q   = {high_q, low_q[LOW_BITS-1:0]};
  assign cnt_nxt = cnt_q + 1'b1;

  always_comb begin
    if (ctrl_q.pin_sel)      tick = pin_fall;
    else if (ctrl_q.sys_sel) tick = 1'b1;
    else                     tick = presc_tick;
  end

  assign enable = ctrl_q.run & (~ctrl_q.gate_en | gate_lvl);
  assign step   = enable & tick & ~(wr_low | wr_high);
  assign wrap   = step & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
    end else begin
      if (wr_low)    low_q <= wr_data;
      else if (step) low_q[LOW_BITS-1:0] <= cnt_nxt[LOW_BITS-1:0];
      if (wr_high)   high_q <= wr_data[HIGH_BITS-1:0];
      else if (step) high_q <= cnt_nxt[CNT_BITS-1:LOW_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[B_SYS:B_RUN]);
      if (wrap)         ovf_q <= 1'b1;
      else if (wr_ctrl) ovf_q <= wr_data[B_OVF];
      else if (ovf_ack) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[B_SYS:B_RUN] = ctrl_q;
    ctrl_rd[B_OVF]       = ovf_q;
  end
endmodule

// File: rtl/gated_timer13.sv
module gated_timer13
  import timer13_pkg::*;
#(
  parameter int NCH = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              presc_tick,
  input  logic [NCH-1:0]    cnt_pin,
  input  logic [NCH-1:0]    gate_pin,
  input  logic [NCH-1:0]    ovf_ack,
  output logic [NCH-1:0]    ovf_irq
);
  logic [NCH-1:0][DATA_W-1:0]    ch_low;
  logic [NCH-1:0][HIGH_BITS-1:0] ch_high;
  logic [NCH-1:0][DATA_W-1:0]    ch_ctrl;
  logic [NCH-1:0][CNT_BITS-1:0]  ch_cnt;

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr[1:0]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = wr_en && (addr[ADDR_W-1:2] == CH_W'(i));

    timer13_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_low(hit && sel == SEL_LOW),
      .wr_high(hit && sel == SEL_HIGH),
      .wr_ctrl(hit && sel == SEL_CTRL),
      .wr_data(wr_data),
      .presc_tick(presc_tick),
      .cnt_pin(cnt_pin[i]),
      .gate_pin(gate_pin[i]),
      .ovf_ack(ovf_ack[i]),
      .low_q(ch_low[i]),
      .high_q(ch_high[i]),
      .ctrl_rd(ch_ctrl[i]),
      .cnt_q(ch_cnt[i]),
      .ovf_q(ovf_irq[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr[ADDR_W-1:2] == CH_W'(i)) begin
        case (sel)
          SEL_LOW:  rd_data = ch_low[i];
          SEL_HIGH: rd_data = ch_high[i];
          SEL_CTRL: rd_data = ch_ctrl[i];
          default:  rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/timer13_checker.sv
module timer13_checker #(
  parameter int NCH = 2,
  parameter int ADDR_W = 3,
  parameter int CNT_BITS = 13,
  parameter int DATA_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            addr,
  input logic [NCH-1:0]               ovf_ack,
  input logic [NCH-1:0]               ovf_irq,
  input logic [NCH-1:0][CNT_BITS-1:0] ch_cnt,
  input logic [NCH-1:0][DATA_W-1:0]   ch_low,
  input logic [NCH-1:0][DATA_W-1:0]   ch_ctrl
);
  localparam int CH_W = ADDR_W - 2;
  localparam logic [CNT_BITS-1:0] ALL1 = '1;

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic wr_cnt, wr_ctl;
    assign wr_cnt = wr_en && addr[ADDR_W-1:2] == CH_W'(i) && !addr[1];
    assign wr_ctl = wr_en && addr[ADDR_W-1:2] == CH_W'(i) && addr[1:0] == 2'd2;

    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_ctrl[i][0] && !wr_cnt) |=> $stable(ch_cnt[i]));

    p_upper_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> $stable(ch_low[i][7:5]));

    p_single_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> (ch_cnt[i] == $past(ch_cnt[i]) ||
                   ch_cnt[i] == CNT_BITS'($past(ch_cnt[i]) + 1'b1)));

    p_wrap_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_cnt && ch_cnt[i] == ALL1) ##1 (ch_cnt[i] == '0) |-> ovf_irq[i]);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_ack[i] && !wr_ctl && ch_cnt[i] != ALL1) |=> !ovf_irq[i]);
  end
endmodule

bind gated_timer13 timer13_checker #(
  .NCH(NCH), .ADDR_W(ADDR_W), .CNT_BITS(timer13_pkg::CNT_BITS), .DATA_W(timer13_pkg::DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .ovf_ack(ovf_ack), .ovf_irq(ovf_irq),
  .ch_cnt(ch_cnt), .ch_low(ch_low), .ch_ctrl(ch_ctrl)
);

// File: tb/tb_gated_timer13.sv
module tb_gated_timer13;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       presc_tick = 1'b0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] ovf_ack = 2'b00;
  logic [1:0] ovf_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  gated_timer13 dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .presc_tick(presc_tick), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ovf_ack(ovf_ack), .ovf_irq(ovf_irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // write occupies the posedge between two negedges
  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1ns d = rd_data;
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic clear_cnt(int ch);
    wr(3'(ch*4+0), 8'h00);
    wr(3'(ch*4+1), 8'h00);
  endtask

  task automatic t_reset;
    rd_check("R9 low0", 3'd0, 8'h00);
    rd_check("R9 high0", 3'd1, 8'h00);
    rd_check("R9 ctrl0", 3'd2, 8'h00);
    rd_check("R9 ctrl1", 3'd6, 8'h00);
    check("R9 irq", {6'd0, ovf_irq}, 8'h00);
    rd_check("R10 sel3", 3'd3, 8'h00);
  endtask

  // start then stop after W idle negedges gives W+2 system-clock steps
  task automatic t_sysclk;
    clear_cnt(0);
    wr(3'd2, 8'h09);
    repeat (10) @(negedge clk);
    wr(3'd2, 8'h08);
    rd_check("R2 sysclk 12 steps", 3'd0, 8'd12);
    repeat (4) @(negedge clk);
    rd_check("R3 holds when run=0", 3'd0, 8'd12);
  endtask

  task automatic t_run_keeps;
    wr(3'd0, 8'h05); wr(3'd1, 8'h02);
    wr(3'd2, 8'h01);
    rd_check("R4 low kept", 3'd0, 8'h05);
    rd_check("R4 high kept", 3'd1, 8'h02);
    rd_check("R4 ctrl", 3'd2, 8'h01);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_presc;
    clear_cnt(0);
    wr(3'd2, 8'h01);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); presc_tick = 1'b1;
      @(negedge clk); presc_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    wr(3'd2, 8'h00);
    rd_check("R2 prescaled 3 ticks", 3'd0, 8'd3);
  endtask

  task automatic t_carry;
    wr(3'd0, 8'hFF); wr(3'd1, 8'h07);
    wr(3'd2, 8'h09);
    wr(3'd2, 8'h08);
    rd_check("R5 low wraps, upper bits kept", 3'd0, 8'hE1);
    rd_check("R5 carry into high", 3'd1, 8'h08);
  endtask

  task automatic t_priority;
    clear_cnt(0);
    wr(3'd2, 8'h09);
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h10);
    wr(3'd2, 8'h08);
    rd_check("R8 low after writes", 3'd0, 8'h06);
    rd_check("R8 high after writes", 3'd1, 8'h10);
  endtask

  task automatic t_overflow;
    wr(3'd0, 8'h1E); wr(3'd1, 8'hFF);
    wr(3'd2, 8'h09);
    wr(3'd2, 8'h08);   // wrap lands on this edge
    rd_check("R6 count zero", 3'd1, 8'h00);
    rd_check("R7 wrap beats ctrl clear", 3'd2, 8'h18);
    check("R6 irq set", {7'd0, ovf_irq[0]}, 8'h01);
    @(negedge clk); ovf_ack[0] = 1'b1;
    @(negedge clk); ovf_ack[0] = 1'b0;
    #1ns check("R7 ack clears", {7'd0, ovf_irq[0]}, 8'h00);
    wr(3'd2, 8'h10);
    #1ns check("R7 sw set", {7'd0, ovf_irq[0]}, 8'h01);
    wr(3'd2, 8'h00);
    #1ns check("R7 sw clear", {7'd0, ovf_irq[0]}, 8'h00);
  endtask

  task automatic t_pin;
    clear_cnt(0);
    wr(3'd2, 8'h05);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); cnt_pin[0] = 1'b0;
      repeat (3) @(negedge clk);
      cnt_pin[0] = 1'b1;
      repeat (3) @(negedge clk);
    end
    @(negedge clk); cnt_pin[0] = 1'b0;
    repeat (8) @(negedge clk);
    cnt_pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd2, 8'h00);
    rd_check("R1 five falling edges", 3'd0, 8'd5);
  endtask

  task automatic t_gate;
    clear_cnt(0);
    wr(3'd2, 8'h0B);
    repeat (4) @(negedge clk);
    rd_check("R3 gate low holds", 3'd0, 8'd0);
    gate_pin[0] = 1'b1;
    repeat (6) @(negedge clk);
    gate_pin[0] = 1'b0;
    repeat (5) @(negedge clk);
    wr(3'd2, 8'h0A);
    rd_check("R3 gate width 6", 3'd0, 8'd6);
    @(negedge clk); gate_pin[0] = 1'b1;
    repeat (6) @(negedge clk);
    gate_pin[0] = 1'b0;
    repeat (3) @(negedge clk);
    rd_check("R3 gate high but run=0", 3'd0, 8'd6);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_channels;
    wr(3'd0, 8'h11); wr(3'd1, 8'h22);
    clear_cnt(1);
    wr(3'd6, 8'h09);
    repeat (3) @(negedge clk);
    wr(3'd6, 8'h08);
    rd_check("R10 ch1 counted", 3'd4, 8'd5);
    rd_check("R10 ch0 untouched low", 3'd0, 8'h11);
    rd_check("R10 ch0 untouched high", 3'd1, 8'h22);
    check("R10 no irq", {6'd0, ovf_irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sysclk();
    t_run_keeps();
    t_presc();
    t_carry();
    t_priority();
    t_overflow();
    t_pin();
    t_gate();
    t_channels();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule